// File: doc/BRIEF.md
# Power-Mode and Reset Sequencer

This controller decides the operating mode of a metering-style chip from a 32 kHz always-on clock. It watches the external reset input, the system-power-good output of a power-fault comparator, a battery-present flag and a software request for a low-power mode. From these it drives the wake signal, the PLL-settled status, the processor reset, the configuration reset, a mode-change interrupt and the hardware watchdog enable. It also reports one of four modes: MISSION, BROWNOUT, LCD or SLEEP.

After reset, a timer holds the processor. The timer runs long when system power is present and only briefly when it is absent. A settle counter turns system-power-good into a PLL-ready flag. The mode machine uses that flag to return to MISSION by one of two paths. From BROWNOUT, configuration is kept and an interrupt is raised. From LCD or SLEEP, wake was low, so configuration comes back cleared and no interrupt is raised.

Top module: `pwr_seq`

## Requirements
- R1: While `rst` is high, one clock edge after it is sampled the outputs are `wake`=0, `cpu_rst`=1, `cfg_rst`=1, `pll_ok`=0, `wdog_en`=0, `mode_irq`=0, `irq_status`=0 and `mode`=2'b11. The mode holds 2'b11 for the whole reset timer.
- R2: Mode codes are 2'b00 MISSION, 2'b01 BROWNOUT, 2'b10 LCD and 2'b11 SLEEP. Call the first edge that samples `rst` low T1. If `pwr_good` is high at T1, the mode becomes MISSION at edge T(RST_CYCLES+2), with `wake`=1 and `cpu_rst`=0. This requires PLL_CYCLES <= RST_CYCLES.
- R3: If `pwr_good` is low at T1 and `bat_ok` is high, the mode becomes BROWNOUT at edge T(NOPWR_CYCLES+2), with `wake`=1, `cpu_rst`=0 and `cfg_rst`=0.
- R4: If `pwr_good` and `bat_ok` are both low at T1, the mode becomes SLEEP at edge T(NOPWR_CYCLES+2) and `cpu_rst` stays 1.
- R5: `pll_ok` rises at the PLL_CYCLES-th consecutive edge that samples `pwr_good` high. It clears at the first edge that samples `pwr_good` low. A drop before completion restarts the count.
- R6: In MISSION, the first edge that samples `pwr_good` low with `bat_ok` high moves the mode to BROWNOUT. At that edge `wake` stays 1, `cfg_rst` stays 0 and `wdog_en` goes 0.
- R7: In MISSION, the first edge that samples `pwr_good` low with `bat_ok` low moves the mode to SLEEP, with `wake`=0, `cfg_rst`=1 and `cpu_rst`=1.
- R8: In BROWNOUT, the edge after `pll_ok` rises moves the mode to MISSION. At that edge `mode_irq` pulses high for exactly one cycle, `irq_status` sets, and `cfg_rst` stays 0.
- R9: In LCD or SLEEP, `wake`=0, `cfg_rst`=1 and `cpu_rst`=1. The edge after `pll_ok` rises moves the mode to MISSION and releases `cfg_rst` with no `mode_irq` pulse.
- R10: In BROWNOUT with power absent, `sw_req`=1 moves the mode at the next edge to LCD when `sw_deep`=0 and to SLEEP when `sw_deep`=1. `sw_req` has no effect in MISSION.
- R11: `irq_status` stays set until an edge samples `irq_clr`=1, which clears it.
- R12: `wdog_en` is 1 exactly when the mode is MISSION.
- R13: In BROWNOUT, an edge that samples `bat_ok` low moves the mode to SLEEP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 kHz always-on clock |
| rst | input | 1 | External reset, synchronous, active high |
| pwr_good | input | 1 | System power present (comparator output) |
| bat_ok | input | 1 | Battery present |
| sw_req | input | 1 | Software request to leave BROWNOUT for a low-power mode |
| sw_deep | input | 1 | Low-power mode select: 0 LCD, 1 SLEEP |
| irq_clr | input | 1 | Write-one-to-clear for the sticky interrupt bit |
| wake | output | 1 | Wake signal; low in reset, LCD and SLEEP |
| pll_ok | output | 1 | PLL settled after power return |
| cpu_rst | output | 1 | Processor reset |
| cfg_rst | output | 1 | Configuration register reset |
| mode_irq | output | 1 | One-cycle mode-change interrupt pulse |
| irq_status | output | 1 | Sticky interrupt status |
| wdog_en | output | 1 | Hardware watchdog enable |
| mode | output | 2 | Current mode code |

## Verification
The assertions assume `pwr_good`, `bat_ok` and the software inputs are already synchronous to `clk`. They also assume the parameters satisfy PLL_CYCLES <= RST_CYCLES, so a powered boot always finds the PLL settled. The stimulus changes inputs only between edges and uses a small parameter set (RST_CYCLES=12, NOPWR_CYCLES=2, PLL_CYCLES=6) that keeps this ordering. Power-loss and power-return patterns, including drops partway through the settle window, are swept with the battery both present and absent.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    ST_HALT, ST_TIMER, ST_MISSION, ST_BROWN, ST_LCD, ST_SLEEP
  } seq_state_t;

  localparam logic [1:0] MODE_MISSION = 2'b00;
  localparam logic [1:0] MODE_BROWN   = 2'b01;
  localparam logic [1:0] MODE_LCD     = 2'b10;
  localparam logic [1:0] MODE_SLEEP   = 2'b11;
endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int LONG_CYCLES  = 4100,
  parameter int SHORT_CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic long_sel,
  output logic done
);
  localparam int MAXC = (LONG_CYCLES > SHORT_CYCLES) ? LONG_CYCLES : SHORT_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_CYCLES - 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last_q;
  logic          running;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      last_q  <= '0;
      running <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        running <= 1'b1;
        cnt     <= '0;
        last_q  <= long_sel ? LONG_LAST : SHORT_LAST;
      end else if (running) begin
        if (cnt == last_q) begin
          running <= 1'b0;
          done    <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (rst)
    running |-> (cnt <= last_q)); // R2
endmodule

// File: rtl/pwr_seq_pll.sv
module pwr_seq_pll #(
  parameter int SETTLE_CYCLES = 2048
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_good,
  output logic ready
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !pwr_good) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      if (cnt == LAST) ready <= 1'b1;
      cnt <= cnt + 1'b1;
    end
  end

  AST_PLL_DROP: assert property (@(posedge clk) disable iff (rst)
    !pwr_good |=> !ready); // R5
  AST_PLL_ROSE_POWERED: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(pwr_good)); // R5
endmodule

// File: rtl/pwr_seq_irq.sv
module pwr_seq_irq (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic pulse,
  output logic status
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pulse  <= 1'b0;
      status <= 1'b0;
    end else begin
      pulse <= set;
      if (set)      status <= 1'b1;
      else if (clr) status <= 1'b0;
    end
  end

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse); // R8
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
  import pwr_seq_pkg::*;
#(
  parameter int RST_CYCLES   = 4100,
  parameter int NOPWR_CYCLES = 2,
  parameter int PLL_CYCLES   = 2048
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_good,
  input  logic       bat_ok,
  input  logic       sw_req,
  input  logic       sw_deep,
  input  logic       irq_clr,
  output logic       wake,
  output logic       pll_ok,
  output logic       cpu_rst,
  output logic       cfg_rst,
  output logic       mode_irq,
  output logic       irq_status,
  output logic       wdog_en,
  output logic [1:0] mode
);
  seq_state_t state, state_d;
  logic       tmr_start, tmr_done, irq_set;

  assign tmr_start = (state == ST_HALT);
  assign irq_set   = (state == ST_BROWN) && (state_d == ST_MISSION);

  pwr_seq_timer #(.LONG_CYCLES(RST_CYCLES), .SHORT_CYCLES(NOPWR_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(tmr_start), .long_sel(pwr_good), .done(tmr_done)
  );

  pwr_seq_pll #(.SETTLE_CYCLES(PLL_CYCLES)) u_pll (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .ready(pll_ok)
  );

  pwr_seq_irq u_irq (
    .clk(clk), .rst(rst), .set(irq_set), .clr(irq_clr),
    .pulse(mode_irq), .status(irq_status)
  );

  always_comb begin
    state_d = state;
    unique case (state)
      ST_HALT:  state_d = ST_TIMER;
      ST_TIMER:
        if (tmr_done) begin
          if (pll_ok)      state_d = ST_MISSION;
          else if (bat_ok) state_d = ST_BROWN;
          else             state_d = ST_SLEEP;
        end
      ST_MISSION:
        if (!pwr_good) state_d = bat_ok ? ST_BROWN : ST_SLEEP;
      ST_BROWN:
        if (pll_ok)      state_d = ST_MISSION;
        else if (!bat_ok) state_d = ST_SLEEP;
        else if (sw_req)  state_d = sw_deep ? ST_SLEEP : ST_LCD;
      ST_LCD, ST_SLEEP:
        if (pll_ok) state_d = ST_MISSION;
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_HALT;
      wake    <= 1'b0;
      cpu_rst <= 1'b1;
      cfg_rst <= 1'b1;
      wdog_en <= 1'b0;
      mode    <= MODE_SLEEP;
    end else begin
      state <= state_d;
      unique case (state_d)
        ST_MISSION: begin
          wake <= 1'b1; cpu_rst <= 1'b0; cfg_rst <= 1'b0; wdog_en <= 1'b1; mode <= MODE_MISSION;
        end
        ST_BROWN: begin
          wake <= 1'b1; cpu_rst <= 1'b0; cfg_rst <= 1'b0; wdog_en <= 1'b0; mode <= MODE_BROWN;
        end
        ST_LCD: begin
          wake <= 1'b0; cpu_rst <= 1'b1; cfg_rst <= 1'b1; wdog_en <= 1'b0; mode <= MODE_LCD;
        end
        default: begin
          wake <= 1'b0; cpu_rst <= 1'b1; cfg_rst <= 1'b1; wdog_en <= 1'b0; mode <= MODE_SLEEP;
        end
      endcase
    end
  end

  AST_MISSION_PLL: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_MISSION) |-> pll_ok); // R9
  AST_IRQ_FROM_BROWN: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_irq) |-> (mode == MODE_MISSION) && ($past(mode) == MODE_BROWN)); // R8
endmodule

// File: tb/pwr_seq_test.sv
module pwr_seq_test;
  localparam int RSTC = 12;
  localparam int NOPC = 2;
  localparam int PLLC = 6;

  logic clk = 1'b0;
  logic rst = 1'b1, pwr_good = 1'b0, bat_ok = 1'b0, sw_req = 1'b0, sw_deep = 1'b0, irq_clr = 1'b0;
  logic wake, pll_ok, cpu_rst, cfg_rst, mode_irq, irq_status, wdog_en;
  logic [1:0] mode;
  int errors = 0, checks = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  pwr_seq #(.RST_CYCLES(RSTC), .NOPWR_CYCLES(NOPC), .PLL_CYCLES(PLLC)) uut (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .bat_ok(bat_ok), .sw_req(sw_req),
    .sw_deep(sw_deep), .irq_clr(irq_clr), .wake(wake), .pll_ok(pll_ok), .cpu_rst(cpu_rst),
    .cfg_rst(cfg_rst), .mode_irq(mode_irq), .irq_status(irq_status), .wdog_en(wdog_en), .mode(mode)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pack outputs {wake,cpu_rst,cfg_rst,wdog_en,mode}
  function automatic int outs();
    return {wake, cpu_rst, cfg_rst, wdog_en, mode};
  endfunction

  task automatic boot(input bit pg, input bit bat);
    rst = 1'b1; pwr_good = pg; bat_ok = bat; sw_req = 1'b0; irq_clr = 1'b0;
    step(2);
    rst = 1'b0;
  endtask

  initial begin
    #1;
    // R1 reset state
    step(2);
    chk("R1 reset outputs", {outs(), pll_ok, mode_irq, irq_status}, {6'b011011, 3'b000});

    // R2 R3 R4: boot sweep over power and battery
    for (int pg = 0; pg < 2; pg++) begin
      for (int bt = 0; bt < 2; bt++) begin
        int lim;
        boot(pg[0], bt[0]);
        lim = pg ? RSTC : NOPC;
        step(lim + 1);
        chk("R1 mode held during reset timer", mode, 3);
        step(1);
        if (pg) chk("R2 powered boot -> MISSION", outs(), 6'b100100);
        else if (bt) chk("R3 battery boot -> BROWNOUT", outs(), 6'b100001);
        else chk("R4 dead boot -> SLEEP", outs(), 6'b011011);
        chk("R12 wdog matches MISSION", wdog_en, (mode == 2'b00));
      end
    end

    // R6 R7 R8 R9 R5: power-loss sweep from MISSION
    for (int bt = 0; bt < 2; bt++) begin
      for (int gap = 1; gap < PLLC; gap += 2) begin
        boot(1'b1, bt[0]);
        step(RSTC + 2);
        chk("R2 in MISSION", mode, 0);
        pwr_good = 1'b0;
        step(1);
        chk("R5 pll_ok clears", pll_ok, 0);
        if (bt) chk("R6 loss with battery", outs(), 6'b100001);
        else chk("R7 loss without battery", outs(), 6'b011011);
        // partial settle then drop: restart
        pwr_good = 1'b1;
        step(gap);
        chk("R5 pll_ok low before settle", pll_ok, 0);
        pwr_good = 1'b0;
        step(1);
        pwr_good = 1'b1;
        step(PLLC - 1);
        chk("R5 pll_ok low one short", pll_ok, 0);
        step(1);
        chk("R5 pll_ok rises", pll_ok, 1);
        chk("R8 R9 mode before return", mode, bt ? 1 : 3);
        step(1);
        chk("R8 R9 return to MISSION", outs(), 6'b100100);
        chk("R8 irq pulse only from BROWNOUT", mode_irq, bt);
        chk("R11 status", irq_status, bt);
        step(1);
        chk("R8 irq pulse one cycle", mode_irq, 0);
        step(3);
        chk("R11 status sticky", irq_status, bt);
        irq_clr = 1'b1;
        step(1);
        irq_clr = 1'b0;
        chk("R11 status cleared", irq_status, 0);
      end
    end

    // R10 R9: software requests from BROWNOUT, and ignored in MISSION
    for (int dp = 0; dp < 2; dp++) begin
      boot(1'b0, 1'b1);
      step(NOPC + 2);
      chk("R3 BROWNOUT", mode, 1);
      sw_req = 1'b1; sw_deep = dp[0];
      step(1);
      sw_req = 1'b0;
      chk("R10 request target", outs(), dp ? 6'b011011 : 6'b011010);
      pwr_good = 1'b1;
      step(PLLC);
      chk("R9 wait for pll", mode, dp ? 3 : 2);
      step(1);
      chk("R9 low power -> MISSION", outs(), 6'b100100);
      chk("R9 no irq", mode_irq, 0);
      sw_req = 1'b1; sw_deep = dp[0];
      step(2);
      sw_req = 1'b0;
      chk("R10 ignored in MISSION", mode, 0);
    end

    // R13: battery loss in BROWNOUT
    boot(1'b0, 1'b1);
    step(NOPC + 2);
    bat_ok = 1'b0;
    step(1);
    chk("R13 battery loss -> SLEEP", outs(), 6'b011011);

    // R1: reset in MISSION returns to reset state
    boot(1'b1, 1'b1);
    step(RSTC + 2);
    rst = 1'b1;
    step(1);
    chk("R1 reset from MISSION", {outs(), pll_ok, irq_status}, {6'b011011, 2'b00});
    done_flag = 1'b1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule